// File: doc/BRIEF.md
# MPPT Open-Circuit Measurement Scheduler

This block sequences fractional open-circuit-voltage tracking for a solar boost harvester. A period timer, a host force request or an external retrigger pulse starts a measurement. During the measurement window the boost converter is halted. At the end of the window the block strobes the ADC and latches the 8-bit source sample as the new open-circuit value (10 mV per LSB). The source regulation target is a programmable fraction of that value and is presented to the analog regulation loop.

All timing counts pulses of `tick_i`, a timebase strobe whose period is one quarter of the shortest base measurement time (12.5 ms in the target system). Base measurement times of 50, 100, 250 and 500 ms are therefore 4, 8, 20 and 40 ticks. When adaptive timing is on, the window scales with the last harvest count, so a bright source is measured briefly and a dim one for longer. A measured or written open-circuit value below the power-up default puts the harvester to sleep.

Top module: `mppt_meas_sched`

## Requirements
- R1: After reset the open-circuit value is 29, halt, strobe, ready and sleep are low, and the regulation target equals the formula of R6 applied to 29.
- R2: No automatic measurement starts while the periodic enable is low, including the first one after reset, or while the period code is 3.
- R3: A force pulse starts a measurement on the next tick (or the same cycle if a tick is present). The window ends with a one-cycle ADC strobe, in the following cycle the open-circuit value equals the ADC input and ready is set, and a ready-clear pulse clears ready.
- R4: With adaptive timing off, halt rises the cycle after the starting tick and the strobe follows exactly W ticks later, where W is 4, 8, 20 or 40 for base-time code 0, 1, 2 or 3.
- R5: With adaptive timing on, the window is sampled at start from the harvest count H: H<13 gives 2×W, 13≤H≤26 gives W, 27≤H≤52 gives W/2, H>52 gives W/4.
- R6: The regulation target is floor(V×(85+3×F)/200), with V the open-circuit value and F the 5-bit fraction code, so F=0 is 42.5% and F=31 is 89.0%.
- R7: A measured value below 29 sets sleep and holds halt high; the next measurement with a value of 29 or more clears both.
- R8: A host write replaces the open-circuit value; a value below 29 sets sleep and halt, a value of 29 or more clears sleep.
- R9: A retrigger pulse while idle makes halt high on the next cycle and restarts the period timer.
- R10: A force pulse during a running measurement is merged into it: exactly one strobe results.
- R11: With periodic enable on and period code P in 0..2, a new measurement starts on the (64<<P)×W-th tick after the end of the previous one; for P=0, W=4 and a tick every 4 clocks consecutive strobes are 1040 clocks apart.
- R12: The ADC strobe is never high for two consecutive cycles, and the open-circuit value changes only after a strobe or a host write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase strobe, one quarter of the shortest base time |
| tmeas_sel_i | input | 2 | Base measurement time code |
| tper_sel_i | input | 2 | Period code, 3 disables automatic measurement |
| per_en_i | input | 1 | Periodic measurement enable |
| adapt_win_i | input | 1 | Adaptive window enable |
| frac_i | input | 5 | Fraction code for the regulation target |
| force_i | input | 1 | Force-measure pulse |
| retrig_i | input | 1 | Retrigger pulse, immediate measurement |
| host_voc_we_i | input | 1 | Host write strobe for the open-circuit value |
| host_voc_i | input | 8 | Host write data |
| adc_data_i | input | 8 | ADC sample of the source voltage |
| harv_cnt_i | input | 16 | Last harvest count |
| ready_clr_i | input | 1 | Clears the ready flag |
| halt_o | output | 1 | Boost halt request |
| adc_strobe_o | output | 1 | ADC sample strobe |
| voc_o | output | 8 | Stored open-circuit value |
| vreg_o | output | 8 | Source regulation target |
| ready_o | output | 1 | New measurement available |
| sleep_o | output | 1 | Sleep request |

## Verification
The bench uses the default parameters: 8-bit values, a 16-bit harvest count, thresholds 13/26/52 and a default of 29. It drives a tick every four clocks. At that rate the longest window (80 ticks) and a full 64×W period fit in a few thousand cycles. This keeps every window length, every harvest-count threshold edge and a periodic interval measurable at exact clock counts. The small default value lets the sleep boundary be probed at 28 and 29 by both measurement and host write.

// File: rtl/mppt_sched_pkg.sv
package mppt_sched_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEAS = 2'd1,
        ST_CAPT = 2'd2
    } sched_st_e;

    // base measurement time in ticks (quarters of the shortest base time)
    function automatic logic [6:0] tmeas_ticks(input logic [1:0] code);
        case (code)
            2'd0:    tmeas_ticks = 7'd4;
            2'd1:    tmeas_ticks = 7'd8;
            2'd2:    tmeas_ticks = 7'd20;
            default: tmeas_ticks = 7'd40;
        endcase
    endfunction

endpackage

// File: rtl/mppt_win_sel.sv
module mppt_win_sel #(
    parameter int HCNT_W  = 16,
    parameter int THR_LO  = 13,
    parameter int THR_MID = 26,
    parameter int THR_HI  = 52,
    parameter int WIN_W   = 7
) (
    input  logic [1:0]        tmeas_sel_i,
    input  logic              adapt_i,
    input  logic [HCNT_W-1:0] harv_i,
    output logic [WIN_W-1:0]  win_o
);
    import mppt_sched_pkg::*;

    logic [WIN_W-1:0] base;

    always_comb begin
        base = WIN_W'(tmeas_ticks(tmeas_sel_i));
        if (!adapt_i)
            win_o = base;
        else if (harv_i < HCNT_W'(THR_LO))
            win_o = base << 1;
        else if (harv_i <= HCNT_W'(THR_MID))
            win_o = base;
        else if (harv_i <= HCNT_W'(THR_HI))
            win_o = base >> 1;
        else
            win_o = base >> 2;
    end

endmodule

// File: rtl/mppt_period_sel.sv
module mppt_period_sel #(
    parameter int PER_W = 14
) (
    input  logic [1:0]       tmeas_sel_i,
    input  logic [1:0]       tper_sel_i,
    output logic [PER_W-1:0] per_len_o,
    output logic             per_ok_o
);
    import mppt_sched_pkg::*;

    int unsigned base;
    int unsigned mult;

    always_comb begin
        base      = 32'(tmeas_ticks(tmeas_sel_i));
        mult      = 32'd64 << tper_sel_i;
        per_ok_o  = (tper_sel_i != 2'd3);
        per_len_o = PER_W'(base * mult);
    end

endmodule

// File: rtl/mppt_frac_mult.sv
module mppt_frac_mult #(
    parameter int VOC_W  = 8,
    parameter int FRAC_W = 5,
    parameter int OFS    = 85,
    parameter int STEP   = 3,
    parameter int DEN    = 200
) (
    input  logic [VOC_W-1:0]  voc_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [VOC_W-1:0]  target_o
);
    localparam int PROD_W = VOC_W + 10;

    logic [PROD_W-1:0] coef;
    logic [PROD_W-1:0] prod;

    always_comb begin
        coef     = PROD_W'(OFS) + PROD_W'(STEP) * PROD_W'(frac_i);
        prod     = PROD_W'(voc_i) * coef;
        target_o = VOC_W'(prod / PROD_W'(DEN));
    end

endmodule

// File: rtl/mppt_meas_sched.sv
module mppt_meas_sched #(
    parameter int VOC_W     = 8,
    parameter int FRAC_W    = 5,
    parameter int HCNT_W    = 16,
    parameter int VOC_DFLT  = 29,
    parameter int THR_LO    = 13,
    parameter int THR_MID   = 26,
    parameter int THR_HI    = 52,
    parameter int FRAC_OFS  = 85,
    parameter int FRAC_STEP = 3,
    parameter int FRAC_DEN  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [1:0]        tmeas_sel_i,
    input  logic [1:0]        tper_sel_i,
    input  logic              per_en_i,
    input  logic              adapt_win_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              force_i,
    input  logic              retrig_i,
    input  logic              host_voc_we_i,
    input  logic [VOC_W-1:0]  host_voc_i,
    input  logic [VOC_W-1:0]  adc_data_i,
    input  logic [HCNT_W-1:0] harv_cnt_i,
    input  logic              ready_clr_i,
    output logic              halt_o,
    output logic              adc_strobe_o,
    output logic [VOC_W-1:0]  voc_o,
    output logic [VOC_W-1:0]  vreg_o,
    output logic              ready_o,
    output logic              sleep_o
);
    import mppt_sched_pkg::*;

    localparam int WIN_W = 7;
    localparam int PER_W = $clog2(256 * 40 + 1);

    typedef struct packed {
        sched_st_e        st;
        logic [PER_W-1:0] pcnt;
        logic [WIN_W-1:0] wlen;
        logic [WIN_W-1:0] wcnt;
        logic             fpend;
        logic             first;
        logic             strobe;
        logic [VOC_W-1:0] voc;
        logic             rdy;
        logic             slp;
    } sched_t;

    sched_t q, d;

    logic [WIN_W-1:0] win_len;
    logic [PER_W-1:0] per_len;
    logic             per_ok;
    logic             auto_en;
    logic             go;

    mppt_win_sel #(
        .HCNT_W (HCNT_W),
        .THR_LO (THR_LO),
        .THR_MID(THR_MID),
        .THR_HI (THR_HI),
        .WIN_W  (WIN_W)
    ) u_win (
        .tmeas_sel_i(tmeas_sel_i),
        .adapt_i    (adapt_win_i),
        .harv_i     (harv_cnt_i),
        .win_o      (win_len)
    );

    mppt_period_sel #(
        .PER_W(PER_W)
    ) u_per (
        .tmeas_sel_i(tmeas_sel_i),
        .tper_sel_i (tper_sel_i),
        .per_len_o  (per_len),
        .per_ok_o   (per_ok)
    );

    mppt_frac_mult #(
        .VOC_W (VOC_W),
        .FRAC_W(FRAC_W),
        .OFS   (FRAC_OFS),
        .STEP  (FRAC_STEP),
        .DEN   (FRAC_DEN)
    ) u_mult (
        .voc_i   (q.voc),
        .frac_i  (frac_i),
        .target_o(vreg_o)
    );

    always_comb begin
        d        = q;
        d.strobe = 1'b0;
        auto_en  = per_en_i && per_ok;
        go       = 1'b0;

        if (ready_clr_i)
            d.rdy = 1'b0;

        if (host_voc_we_i) begin
            d.voc = host_voc_i;
            d.slp = (host_voc_i < VOC_W'(VOC_DFLT));
        end

        case (q.st)
            ST_IDLE: begin
                if (force_i)
                    d.fpend = 1'b1;
                if (auto_en && tick_i)
                    d.pcnt = q.pcnt + 1'b1;
                go = retrig_i ||
                     (tick_i && (q.fpend || force_i ||
                                 (auto_en && (q.first || q.pcnt == per_len - 1'b1))));
                if (go) begin
                    d.st    = ST_MEAS;
                    d.wlen  = win_len;
                    d.wcnt  = '0;
                    d.fpend = 1'b0;
                    d.first = 1'b0;
                    d.pcnt  = '0;
                end
            end
            ST_MEAS: begin
                if (tick_i) begin
                    if (q.wcnt == q.wlen - 1'b1) begin
                        d.st     = ST_CAPT;
                        d.strobe = 1'b1;
                    end else begin
                        d.wcnt = q.wcnt + 1'b1;
                    end
                end
            end
            ST_CAPT: begin
                d.st   = ST_IDLE;
                d.voc  = adc_data_i;
                d.slp  = (adc_data_i < VOC_W'(VOC_DFLT));
                d.rdy  = 1'b1;
                d.pcnt = '0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.first  <= 1'b1;
            q.voc    <= VOC_W'(VOC_DFLT);
        end else begin
            q <= d;
        end
    end

    assign halt_o       = (q.st != ST_IDLE) || q.slp;
    assign adc_strobe_o = q.strobe;
    assign voc_o        = q.voc;
    assign ready_o      = q.rdy;
    assign sleep_o      = q.slp;

    // R12
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe_o |=> !adc_strobe_o);

    // R3
    ready_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe_o |=> ready_o);

    // R12
    voc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_strobe_o && !host_voc_we_i) |=> $stable(voc_o));

    // R7
    sleep_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> halt_o);

    // R4
    strobe_in_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_strobe_o |-> halt_o);

    // R9
    retrig_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (retrig_i && !adc_strobe_o) |=> halt_o);

    // R6
    target_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vreg_o <= voc_o);

endmodule

// File: tb/tb_mppt_meas_sched.sv
module tb_mppt_meas_sched;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] tmeas_sel_i = 2'd0;
    logic [1:0] tper_sel_i = 2'd0;
    logic       per_en_i = 1'b0;
    logic       adapt_win_i = 1'b0;
    logic [4:0] frac_i = 5'd25;
    logic       force_i = 1'b0;
    logic       retrig_i = 1'b0;
    logic       host_voc_we_i = 1'b0;
    logic [7:0] host_voc_i = 8'd0;
    logic [7:0] adc_data_i = 8'd0;
    logic [15:0] harv_cnt_i = 16'd0;
    logic       ready_clr_i = 1'b0;
    logic       halt_o, adc_strobe_o, ready_o, sleep_o;
    logic [7:0] voc_o, vreg_o;

    mppt_meas_sched dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .tmeas_sel_i(tmeas_sel_i), .tper_sel_i(tper_sel_i),
        .per_en_i(per_en_i), .adapt_win_i(adapt_win_i), .frac_i(frac_i),
        .force_i(force_i), .retrig_i(retrig_i),
        .host_voc_we_i(host_voc_we_i), .host_voc_i(host_voc_i),
        .adc_data_i(adc_data_i), .harv_cnt_i(harv_cnt_i),
        .ready_clr_i(ready_clr_i), .halt_o(halt_o),
        .adc_strobe_o(adc_strobe_o), .voc_o(voc_o), .vreg_o(vreg_o),
        .ready_o(ready_o), .sleep_o(sleep_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    win;
        int    adc;
        int    vreg;
        bit    slp;
        string tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int strobe_cnt = 0;
    int last_strobe = 0;
    int halt_rise = 0;
    bit prev_halt = 1'b0;

    function automatic int exp_vreg(input int v, input int f);
        return (v * (85 + 3 * f)) / 200;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // timebase: one tick every 4 clocks
    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tick_i = (tc == 3);
            tc = (tc + 1) % 4;
        end
    end

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (halt_o && !prev_halt) halt_rise = cyc;
            prev_halt = halt_o;
            if (adc_strobe_o) begin
                strobe_cnt++;
                last_strobe = cyc;
                if (sb.size() == 0) begin
                    chk(1'b0, "R10", "unexpected strobe", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.win != 0)
                        chk(cyc - halt_rise == e.win, e.tag, "window cycles", cyc - halt_rise, e.win);
                    @(negedge clk);
                    cyc++;
                    prev_halt = halt_o;
                    chk(voc_o == 8'(e.adc), e.tag, "voc", int'(voc_o), e.adc);
                    chk(vreg_o == 8'(e.vreg), e.tag, "vreg", int'(vreg_o), e.vreg);
                    chk(sleep_o == e.slp, e.tag, "sleep", int'(sleep_o), int'(e.slp));
                    chk(ready_o == 1'b1, "R3", "ready after strobe", int'(ready_o), 1);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R3", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic expect_item(input int adc, input int win, input string tag);
        exp_t e;
        e.win = win;
        e.adc = adc;
        e.vreg = exp_vreg(adc, int'(frac_i));
        e.slp = (adc < 29);
        e.tag = tag;
        adc_data_i = 8'(adc);
        sb.push_back(e);
    endtask

    task automatic wait_done();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_force();
        @(negedge clk); force_i = 1'b1;
        @(negedge clk); force_i = 1'b0;
    endtask

    task automatic do_force(input int adc, input int win, input string tag);
        expect_item(adc, win, tag);
        pulse_force();
        wait_done();
    endtask

    task automatic host_write(input int v);
        @(negedge clk); host_voc_we_i = 1'b1; host_voc_i = 8'(v);
        @(negedge clk); host_voc_we_i = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int s1;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(voc_o == 8'd29, "R1", "voc reset", int'(voc_o), 29);
        chk(vreg_o == 8'(exp_vreg(29, 25)), "R1", "vreg reset", int'(vreg_o), exp_vreg(29, 25));
        chk(!halt_o && !adc_strobe_o, "R1", "halt/strobe reset", int'(halt_o), 0);
        chk(!ready_o && !sleep_o, "R1", "ready/sleep reset", int'(ready_o), 0);

        // R2 periodic disabled: no first measurement
        repeat (400) @(negedge clk);
        chk(strobe_cnt == 0, "R2", "strobes with periodic off", strobe_cnt, 0);

        // R3 R4 force, base code 0
        do_force(150, 16, "R3");
        chk(ready_o, "R3", "ready set", int'(ready_o), 1);
        @(negedge clk); ready_clr_i = 1'b1;
        @(negedge clk); ready_clr_i = 1'b0;
        @(negedge clk);
        chk(!ready_o, "R3", "ready cleared", int'(ready_o), 0);

        // R4 base codes 1 and 2
        tmeas_sel_i = 2'd1;
        do_force(80, 32, "R4");
        tmeas_sel_i = 2'd2;
        do_force(60, 80, "R4");

        // R5 adaptive window edges
        tmeas_sel_i = 2'd0;
        adapt_win_i = 1'b1;
        harv_cnt_i = 16'd12; do_force(100, 32, "R5");
        harv_cnt_i = 16'd13; do_force(101, 16, "R5");
        harv_cnt_i = 16'd26; do_force(102, 16, "R5");
        harv_cnt_i = 16'd27; do_force(103, 8, "R5");
        harv_cnt_i = 16'd52; do_force(104, 8, "R5");
        harv_cnt_i = 16'd53; do_force(105, 4, "R5");
        tmeas_sel_i = 2'd1;
        harv_cnt_i = 16'd100; do_force(106, 8, "R5");
        tmeas_sel_i = 2'd0;
        adapt_win_i = 1'b0;

        // R6 fraction extremes and a live fraction change
        frac_i = 5'd0;  do_force(200, 16, "R6");
        frac_i = 5'd31; do_force(255, 16, "R6");
        @(negedge clk); frac_i = 5'd10;
        @(negedge clk);
        chk(vreg_o == 8'd146, "R6", "vreg after fraction change", int'(vreg_o), 146);
        frac_i = 5'd25;

        // R7 low measurement -> sleep, then boundary value clears it
        do_force(20, 16, "R7");
        chk(halt_o && sleep_o, "R7", "halt in sleep", int'(halt_o), 1);
        do_force(29, 0, "R7");
        chk(!halt_o && !sleep_o, "R7", "sleep cleared at default", int'(sleep_o), 0);

        // R8 host writes
        host_write(28);
        chk(voc_o == 8'd28, "R8", "voc host write", int'(voc_o), 28);
        chk(sleep_o && halt_o, "R8", "sleep on low write", int'(sleep_o), 1);
        host_write(29);
        chk(!sleep_o && !halt_o, "R8", "sleep off at default write", int'(sleep_o), 0);
        chk(vreg_o == 8'(exp_vreg(29, 25)), "R8", "vreg after write", int'(vreg_o), exp_vreg(29, 25));

        // R10 merged force
        n0 = strobe_cnt;
        expect_item(70, 16, "R10");
        pulse_force();
        repeat (6) @(negedge clk);
        chk(halt_o, "R10", "measurement running", int'(halt_o), 1);
        pulse_force();
        wait_done();
        repeat (100) @(negedge clk);
        chk(strobe_cnt - n0 == 1, "R10", "strobes for merged force", strobe_cnt - n0, 1);

        // R9 retrigger
        expect_item(90, 0, "R9");
        @(negedge clk); retrig_i = 1'b1;
        @(negedge clk); retrig_i = 1'b0;
        chk(halt_o, "R9", "halt after retrigger", int'(halt_o), 1);
        wait_done();

        // R11 periodic interval
        per_en_i = 1'b1;
        tper_sel_i = 2'd0;
        expect_item(110, 16, "R11");
        wait_done();
        s1 = last_strobe;
        expect_item(120, 16, "R11");
        wait_done();
        chk(last_strobe - s1 == 1040, "R11", "strobe interval", last_strobe - s1, 1040);

        // R2 period code 3 disables
        tper_sel_i = 2'd3;
        n0 = strobe_cnt;
        repeat (1500) @(negedge clk);
        chk(strobe_cnt == n0, "R2", "strobes with period code 3", strobe_cnt - n0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule